// File: doc/BRIEF.md
# GPIO Interrupt Sense and Pending Unit

This block watches a 32-pin input port and turns pin activity into interrupt requests. Each pin passes through a synchronizer. A per-pin detector then evaluates a 4-bit sense code, which selects a level type or an edge type. A detected event is admitted by an accept gate and latches a raw pending flag. Software clears each flag by writing a one to its bit.

A separate enable bit decides whether a pending pin is forwarded. Software sets and clears the enable bits through two write-one registers. A masked-status register shows the pins that are both pending and enabled. Software services them from the lowest-numbered pin upward until that register reads zero. The OR of all masked-status bits drives a single registered interrupt line.

The register port is a simple word interface with a write strobe and an address. Reads return combinationally for the address currently presented.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, all sense fields, accept bits, enable bits and pending bits read zero, and `irq_o` is low.
- R2: The address map is as follows. Addresses 0 to 3 hold the sense fields, and pin n sits at address n>>3, bits (n&7)*4 to (n&7)*4+3. Address 4 is accept. Address 5 is enable-set and address 6 is enable-clear; both read back the enable bits. Address 7 is pending-clear and reads back the raw pending bits. Address 8 is masked status. Each sense field reads back as written and affects only its own pin.
- R3: The sense codes are 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge and 4 = either edge. Codes 5 to 15 detect nothing.
- R4: A detected event sets pending only when the pin's accept bit is 1. Accept is read/write.
- R5: Writing pending-clear clears the pending bits where the data is 1. Bits where the data is 0 are left unchanged.
- R6: Writing 1s to enable-set sets those enable bits. Writing 1s to enable-clear clears them. Zero bits have no effect in either register.
- R7: Masked status reads as pending AND enable.
- R8: When an event and a clear hit the same pin in the same cycle, pending stays set. A held level therefore keeps re-asserting pending across a clear.
- R9: `irq_o` equals the OR of the masked-status bits, delayed by one clock.
- R10: A pending bit set by an edge stays set after the edge has passed, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Asynchronous GPIO pin inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a fresh event on the same pin. From the ports, edge timing through the synchronizer is awkward to align with a write. The bench therefore holds a pin at a level that matches a level sense code and issues the clear. Every cycle then carries a new event, so the collision is certain, and the flag must read set afterwards. The bench sweeps all eight interesting sense codes over several before/after pin patterns with varied accept and enable masks. It also walks a single rising-edge field across all 32 pins to confirm where each field sits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned SNS_W = 4;

  typedef enum logic [SNS_W-1:0] {
    SNS_LOW  = 4'd0,
    SNS_HIGH = 4'd1,
    SNS_FALL = 4'd2,
    SNS_RISE = 4'd3,
    SNS_BOTH = 4'd4
  } sense_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS*SNS_W-1:0] sense_i,
  input  logic [NPINS-1:0]       cur_i,
  input  logic [NPINS-1:0]       prev_i,
  output logic [NPINS-1:0]       evt_o
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_comb begin
      case (sense_i[n*SNS_W +: SNS_W])
        SNS_LOW:  evt_o[n] = ~cur_i[n];
        SNS_HIGH: evt_o[n] = cur_i[n];
        SNS_FALL: evt_o[n] = prev_i[n] & ~cur_i[n];
        SNS_RISE: evt_o[n] = ~prev_i[n] & cur_i[n];
        SNS_BOTH: evt_o[n] = prev_i[n] ^ cur_i[n];
        default:  evt_o[n] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NPINS-1:0]       evt_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   irq_o,
  output logic [NPINS*SNS_W-1:0] sense_o,
  output logic [NPINS-1:0]       pending_o,
  output logic [NPINS-1:0]       accept_o,
  output logic [NPINS-1:0]       enable_o,
  output logic [NPINS-1:0]       status_o,
  output logic [NPINS-1:0]       pclr_o,
  output logic [NPINS-1:0]       eset_o
);
  localparam int unsigned FIELDS = DW / SNS_W;
  localparam int unsigned NSREG  = (NPINS + FIELDS - 1) / FIELDS;
  localparam logic [AW-1:0] A_ACC  = AW'(NSREG);
  localparam logic [AW-1:0] A_ESET = AW'(NSREG + 1);
  localparam logic [AW-1:0] A_ECLR = AW'(NSREG + 2);
  localparam logic [AW-1:0] A_PEND = AW'(NSREG + 3);
  localparam logic [AW-1:0] A_STAT = AW'(NSREG + 4);

  logic [NPINS-1:0] wmask;
  logic [NPINS-1:0] pending_q, accept_q, enable_q, eclr;
  logic             irq_q;
  logic [NSREG*DW-1:0] sense_pad;

  assign wmask  = wdata_i[NPINS-1:0];
  assign pclr_o = (we_i && addr_i == A_PEND) ? wmask : '0;
  assign eset_o = (we_i && addr_i == A_ESET) ? wmask : '0;
  assign eclr   = (we_i && addr_i == A_ECLR) ? wmask : '0;

  for (genvar n = 0; n < NPINS; n++) begin : g_sns
    localparam int unsigned REG = n / FIELDS;
    localparam int unsigned OFS = (n % FIELDS) * SNS_W;
    logic [SNS_W-1:0] fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fld_q <= '0;
      else if (we_i && addr_i == AW'(REG)) fld_q <= wdata_i[OFS +: SNS_W];
    end
    assign sense_o[n*SNS_W +: SNS_W] = fld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      accept_q  <= '0;
      enable_q  <= '0;
      irq_q     <= 1'b0;
    end else begin
      // event beats a same-cycle clear
      pending_q <= (pending_q & ~pclr_o) | (evt_i & accept_q);
      if (we_i && addr_i == A_ACC) accept_q <= wmask;
      enable_q  <= (enable_q | eset_o) & ~eclr;
      irq_q     <= |status_o;
    end
  end

  assign status_o  = pending_q & enable_q;
  assign pending_o = pending_q;
  assign accept_o  = accept_q;
  assign enable_o  = enable_q;
  assign irq_o     = irq_q;
  assign sense_pad = (NSREG*DW)'(sense_o);

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < NSREG)                      rdata_o = sense_pad[int'(addr_i)*DW +: DW];
    else if (addr_i == A_ACC)                      rdata_o = DW'(accept_q);
    else if (addr_i == A_ESET || addr_i == A_ECLR) rdata_o = DW'(enable_q);
    else if (addr_i == A_PEND)                     rdata_o = DW'(pending_q);
    else if (addr_i == A_STAT)                     rdata_o = DW'(status_o);
  end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  logic [NPINS-1:0]       cur_w, prev_w, evt_w;
  logic [NPINS*SNS_W-1:0] sense_w;
  logic [NPINS-1:0]       pend_w, acc_w, ena_w, stat_w, pclr_w, eset_w;

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .cur_o(cur_w), .prev_o(prev_w)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .sense_i(sense_w), .cur_i(cur_w), .prev_i(prev_w), .evt_o(evt_w)
  );

  gpio_irq_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .evt_i(evt_w), .rdata_o(reg_rdata_o), .irq_o(irq_o),
    .sense_o(sense_w), .pending_o(pend_w), .accept_o(acc_w), .enable_o(ena_w),
    .status_o(stat_w), .pclr_o(pclr_w), .eset_o(eset_w)
  );
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPINS-1:0] evt_i,
  input logic [NPINS-1:0] pend_i,
  input logic [NPINS-1:0] acc_i,
  input logic [NPINS-1:0] ena_i,
  input logic [NPINS-1:0] stat_i,
  input logic [NPINS-1:0] pclr_i,
  input logic [NPINS-1:0] eset_i,
  input logic             irq_i
);
  AST_PEND_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & ~$past(pend_i) & ~$past(acc_i)) == '0)); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & $past(pclr_i & ~(evt_i & acc_i))) == '0)); // R5
  AST_ENABLE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(eset_i) & ~ena_i) == '0)); // R6
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_i & acc_i) & ~pend_i) == '0)); // R8
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stat_i) |=> irq_i); // R9
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|stat_i) |=> !irq_i); // R9
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPINS(NPINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_w), .pend_i(pend_w), .acc_i(acc_w),
  .ena_i(ena_w), .stat_i(stat_w), .pclr_i(pclr_w), .eset_i(eset_w), .irq_i(irq_o)
);

// File: tb/tb_gpio_irq_sense.sv
module tb_gpio_irq_sense;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_sense dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] lvl(input int c, input logic [31:0] v);
    return (c == 0) ? ~v : (c == 1) ? v : 32'h0;
  endfunction

  function automatic logic [31:0] edg(input int c, input logic [31:0] a, input logic [31:0] b);
    return (c == 2) ? (a & ~b) : (c == 3) ? (~a & b) : (c == 4) ? (a ^ b) : 32'h0;
  endfunction

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog got=hung exp=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, exp, e2;
    logic [31:0] pa[4] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0F0F_0F0F};
    logic [31:0] pb[4] = '{32'hFFFF_FFFF, 32'h0, 32'h5A5A_5A5A, 32'h00FF_00FF};
    logic [31:0] pg[4] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3C3C_F00F, 32'hFFFF_0000};
    logic [31:0] pe[4] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h1357_9BDF};
    idle(2);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d); chk("R1 reg", d, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 field placement walk
    for (int r = 0; r < 4; r++) wr(4'(r), 32'h7777_7777);
    wr(4, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      logic [31:0] v;
      v = 32'h7777_7777;
      v[(n%8)*4 +: 4] = 4'd3;
      pins = '0;
      wr(4'(n/8), v);
      rd(4'(n/8), d); chk("R2 readback", d, v);
      idle(4);
      wr(7, 32'hFFFF_FFFF);
      pins = '1;
      idle(5);
      rd(7, d); chk("R2 single pin", d, 32'h1 << n);
      wr(4'(n/8), 32'h7777_7777);
    end

    // sense code sweep
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        pins = pa[p];
        wr(4, pg[p]);
        for (int r = 0; r < 4; r++) wr(4'(r), {8{4'(c)}});
        rd(4, d); chk("R4 accept rw", d, pg[p]);
        idle(4);
        wr(7, 32'hFFFF_FFFF);
        exp = lvl(c, pa[p]) & pg[p];
        rd(7, d); chk("R8 clear vs held level", d, exp);
        pins = pb[p];
        idle(5);
        exp = (lvl(c, pa[p]) | edg(c, pa[p], pb[p]) | lvl(c, pb[p])) & pg[p];
        rd(7, d); chk("R3 R4 R10 pending", d, exp);
        wr(6, 32'hFFFF_FFFF);
        wr(5, pe[p]);
        rd(8, d); chk("R7 status", d, exp & pe[p]);
        rd(5, d); chk("R6 enable set", d, pe[p]);
        chk("R9 irq delayed", {31'h0, irq}, 32'h0);
        idle(1);
        chk("R9 irq", {31'h0, irq}, {31'h0, |(exp & pe[p])});
        wr(6, 32'h0000_FFFF);
        rd(6, d); chk("R6 enable clear", d, pe[p] & 32'hFFFF_0000);
        wr(7, 32'hF0F0_F0F0);
        e2 = (exp & ~32'hF0F0_F0F0) | (lvl(c, pb[p]) & pg[p]);
        rd(7, d); chk("R5 partial clear", d, e2);
      end
    end
    done = 1;
    finish_run();
  end
endmodule